// File: doc/BRIEF.md
# Dual-Rail Self-Timed Serial Adder Stage

This block wraps a bit-serial function so that it advances only when data arrives, never on a free-running enable. Every logical bit travels on a pair of rails: a strobe on the true rail carries a 1, and a strobe on the false rail carries a 0. The stage merges the rails of its operand channels into a local fire strobe. Each fire computes one result bit. The result leaves through a register with complementary outputs, so exactly one output rail pulses for each result bit. In this synchronous model every pulse is a one-cycle strobe.

The stage has two operand channels, A and B, and two functions chosen by `addMode`. In add mode it fires once both channels have delivered their current bit, in either order, and emits the serial sum least significant bit first, with the carry held between bits. In pass mode it fires on channel A alone and copies the bit to the output. Channel B is then ignored.

A bit counter closes each serial word of `WIDTH` bits. On the last bit it pulses `wordDone` and clears the carry. The stage then refuses new rail strobes until the downstream stage returns `ackIn`, which gives one handshake per word instead of one per bit. A strobe on both rails of a channel in the same cycle is a protocol violation. It is reported on `protoErr` and then discarded.

Top module: `dual_rail_stage`

## Requirements
- R1: After reset, `qT`, `qF`, `wordDone` and `protoErr` are low, the stage accepts input, the carry is zero and the bit counter is at bit 0.
- R2: `qT` and `qF` are never high in the same cycle. Each result bit drives exactly one of them high for one cycle: `qT` for 1, `qF` for 0.
- R3: In add mode (`addMode`=1), result bit k of a word is bit k of (A + B) mod 2^WIDTH, with operand bits sent least significant first. The result is due on the cycle after the strobe that completes the bit pair.
- R4: In add mode, no result appears while only one channel has delivered its current bit. The result appears on the cycle after the other channel arrives, in either arrival order.
- R5: In pass mode (`addMode`=0), each strobe on channel A gives a result equal to that A bit on the next cycle. Strobes on channel B have no effect.
- R6: `wordDone` pulses for one cycle, together with the result rail of the WIDTH-th bit of a word. The next word starts with a zero carry.
- R7: From the `wordDone` cycle until the cycle in which `ackIn` is high, rail strobes are discarded and produce no result. Strobes are accepted again from the cycle after that `ackIn`.
- R8: A strobe on both rails of one channel in the same cycle raises `protoErr` for one cycle on the next cycle and is discarded. That channel still waits for a valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| addMode | input | 1 | 1 selects serial add, 0 selects pass of channel A |
| aT | input | 1 | Channel A true rail strobe |
| aF | input | 1 | Channel A false rail strobe |
| bT | input | 1 | Channel B true rail strobe |
| bF | input | 1 | Channel B false rail strobe |
| ackIn | input | 1 | Downstream acknowledge of the last word |
| qT | output | 1 | Result true rail strobe |
| qF | output | 1 | Result false rail strobe |
| wordDone | output | 1 | Word completion strobe |
| protoErr | output | 1 | Both-rails violation strobe |

## Verification
Every result, `wordDone` and `protoErr` is due exactly one cycle after the strobe that causes it, because only one register lies between the rails and each output. The bench drives rails on the falling edge. It checks the outputs on the next falling edge, which falls after the one rising edge that captures them. In skewed arrivals it also checks on the intermediate falling edge that nothing has come out yet. The acknowledge is raised in the `wordDone` cycle, and the next word's strobes start on the following falling edge. Strobes sent during the wait phase are checked for silence on the output, and the whole of the next word is then compared bit by bit.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic {
    PH_OPEN = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

  typedef struct packed {
    logic capA;
    logic capB;
    logic fire;
    logic lastBit;
    logic addMode;
  } strobe_t;

endpackage

// File: rtl/drs_rail_rx.sv
module drs_rail_rx (
  input  logic railT,
  input  logic railF,
  output logic arrive,
  output logic clash,
  output logic value
);

  assign arrive = railT ^ railF;
  assign clash  = railT & railF;
  assign value  = railT;

endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addMode,
  input  logic [1:0] arrive,
  input  logic [1:0] clash,
  input  logic       ackIn,
  output strobe_t    stb,
  output logic       protoErr
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  phase_e        phase;
  logic [CW-1:0] bitCnt;
  logic          haveA, haveB;
  logic          open, effA, effB;

  assign open = (phase == PH_OPEN);

  always_comb begin
    stb.addMode = addMode;
    stb.capA    = open & arrive[0] & ~haveA;
    stb.capB    = open & addMode & arrive[1] & ~haveB;
    effA        = haveA | stb.capA;
    effB        = haveB | stb.capB | ~addMode;
    stb.fire    = effA & effB;
    stb.lastBit = stb.fire & (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_OPEN;
      bitCnt   <= '0;
      haveA    <= 1'b0;
      haveB    <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      protoErr <= |clash;
      if (stb.fire) begin
        haveA  <= 1'b0;
        haveB  <= 1'b0;
        bitCnt <= stb.lastBit ? '0 : bitCnt + 1'b1;
      end else begin
        haveA <= haveA | stb.capA;
        haveB <= haveB | stb.capB;
      end
      if (stb.lastBit)
        phase <= PH_HOLD;
      else if (phase == PH_HOLD && ackIn)
        phase <= PH_OPEN;
    end
  end

  // R7
  hold_no_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD) |-> !stb.fire);

  // R8
  clash_no_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clash[0] || clash[1]) |-> !(clash[0] && stb.capA) && !(clash[1] && stb.capB));

endmodule

// File: rtl/drs_datapath.sv
module drs_datapath
  import drs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    valA,
  input  logic    valB,
  output logic    qT,
  output logic    qF,
  output logic    wordDone
);

  localparam int OCW = $clog2(WIDTH) + 1;

  logic bitA, bitB, carry;
  logic opA, opB, resBit, carryNext;

  always_comb begin
    opA       = stb.capA ? valA : bitA;
    opB       = stb.capB ? valB : bitB;
    resBit    = stb.addMode ? (opA ^ opB ^ carry) : opA;
    carryNext = (opA & opB) | (opA & carry) | (opB & carry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitA     <= 1'b0;
      bitB     <= 1'b0;
      carry    <= 1'b0;
      qT       <= 1'b0;
      qF       <= 1'b0;
      wordDone <= 1'b0;
    end else begin
      if (stb.capA) bitA <= valA;
      if (stb.capB) bitB <= valB;
      if (stb.fire)
        carry <= (stb.lastBit || !stb.addMode) ? 1'b0 : carryNext;
      qT       <= stb.fire & resBit;
      qF       <= stb.fire & ~resBit;
      wordDone <= stb.lastBit;
    end
  end

  logic [OCW-1:0] outCnt;
  always_ff @(posedge clk) begin
    if (!rstN) outCnt <= '0;
    else if (qT || qF) outCnt <= wordDone ? '0 : outCnt + 1'b1;
  end

  // R2
  one_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(qT && qF));

  // R6
  word_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> (qT || qF) && (outCnt == OCW'(WIDTH - 1)));

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> (carry == 1'b0));

endmodule

// File: rtl/dual_rail_stage.sv
module dual_rail_stage
  import drs_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NCH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic addMode,
  input  logic aT,
  input  logic aF,
  input  logic bT,
  input  logic bF,
  input  logic ackIn,
  output logic qT,
  output logic qF,
  output logic wordDone,
  output logic protoErr
);

  logic [NCH-1:0] railsT, railsF, arrive, clash, value;
  strobe_t stb;

  assign railsT = {bT, aT};
  assign railsF = {bF, aF};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rx
    drs_rail_rx u_rx (
      .railT  (railsT[ch]),
      .railF  (railsF[ch]),
      .arrive (arrive[ch]),
      .clash  (clash[ch]),
      .value  (value[ch])
    );
  end

  drs_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addMode  (addMode),
    .arrive   (arrive),
    .clash    (clash),
    .ackIn    (ackIn),
    .stb      (stb),
    .protoErr (protoErr)
  );

  drs_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .valA     (value[0]),
    .valB     (value[1]),
    .qT       (qT),
    .qF       (qF),
    .wordDone (wordDone)
  );

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> !(qT || qF));

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past((aT && aF) || (bT && bF)));

endmodule

// File: tb/dual_rail_stage_tb.sv
module dual_rail_stage_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addMode = 1'b1;
  logic aT = 0, aF = 0, bT = 0, bF = 0, ackIn = 0;
  logic qT, qF, wordDone, protoErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_rail_stage #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .addMode(addMode),
    .aT(aT), .aF(aF), .bT(bT), .bF(bF), .ackIn(ackIn),
    .qT(qT), .qF(qF), .wordDone(wordDone), .protoErr(protoErr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveA(logic v);
    aT = v; aF = ~v;
  endtask

  task automatic driveB(logic v);
    bT = v; bF = ~v;
  endtask

  task automatic idle();
    aT = 0; aF = 0; bT = 0; bF = 0;
  endtask

  // skew 0: same cycle, 1: A first, 2: B first (R4)
  task automatic sendBit(logic a, logic b, int skew);
    if (skew == 0) begin
      driveA(a); driveB(b);
    end else if (skew == 1) begin
      driveA(a);
      @(negedge clk); idle();
      check("R4 early", {qT, qF}, 0);
      driveB(b);
    end else begin
      driveB(b);
      @(negedge clk); idle();
      check("R4 early", {qT, qF}, 0);
      driveA(a);
    end
    @(negedge clk); idle();
  endtask

  task automatic giveAck();
    ackIn = 1;
    @(negedge clk);
    ackIn = 0;
  endtask

  task automatic runWord(int a, int b, logic mode, int skew, bit doAck, string req);
    int expWord;
    addMode = mode;
    expWord = mode ? ((a + b) & 255) : (a & 255);
    for (int k = 0; k < W; k++) begin
      sendBit(a[k], b[k], skew);
      check(req, {qT, qF}, expWord[k] ? 2 : 1);
      check("R6 done", wordDone, (k == W - 1) ? 1 : 0);
    end
    if (doAck) giveAck();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 q", {qT, qF}, 0);
    check("R1 done", wordDone, 0);
    check("R1 err", protoErr, 0);

    // R3 sweep of the add function with varied arrival order
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 23)
        runWord(a, b, 1'b1, (a + b) % 3, 1'b1, "R3 sum");

    // R6 carry out of the top bit must not leak into the next word
    runWord(255, 1, 1'b1, 0, 1'b1, "R6 wrap");
    runWord(0, 0, 1'b1, 0, 1'b1, "R6 carry cleared");
    runWord(255, 255, 1'b1, 1, 1'b1, "R3 max");
    runWord(128, 128, 1'b1, 2, 1'b1, "R6 carry cleared");
    runWord(1, 0, 1'b1, 0, 1'b1, "R6 carry cleared");

    // R5 pass mode: B strobes carry inverted data and must be ignored
    for (int a = 0; a < 256; a += 37)
      runWord(a, ~a, 1'b0, 0, 1'b1, "R5 pass");
    addMode = 1'b0;
    for (int k = 0; k < W; k++) begin
      driveA(k[0]);
      @(negedge clk); idle();
      check("R5 pass A only", {qT, qF}, k[0] ? 2 : 1);
    end
    giveAck();

    // R7 strobes during the wait phase produce nothing
    runWord(90, 77, 1'b1, 0, 1'b0, "R3 sum");
    for (int k = 0; k < 3; k++) begin
      driveA(1); driveB(1);
      @(negedge clk); idle();
      check("R7 ignored", {qT, qF}, 0);
    end
    giveAck();
    runWord(3, 5, 1'b1, 0, 1'b1, "R7 next word intact");

    // R8 both rails on channel A are discarded
    addMode = 1'b1;
    aT = 1; aF = 1; driveB(1);
    @(negedge clk); idle();
    check("R8 err", protoErr, 1);
    check("R8 no result", {qT, qF}, 0);
    driveA(0);
    @(negedge clk); idle();
    check("R8 err clear", protoErr, 0);
    check("R8 bit after clash", {qT, qF}, 2);
    for (int k = 1; k < W; k++) begin
      sendBit(1'b0, 1'b0, 0);
      check("R8 rest", {qT, qF}, 1);
      check("R6 done", wordDone, (k == W - 1) ? 1 : 0);
    end
    giveAck();
    runWord(200, 100, 1'b1, 2, 1'b1, "R8 after error");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule